// File: doc/BRIEF.md
# Register Rename Map with Freelist

This block renames architectural register names onto a larger pool of physical registers. A table keeps, for every architectural register, the physical register that currently holds its newest value. Source operands are translated through that table. Each instruction that writes a register is handed a fresh physical register taken from a freelist, and the table entry is replaced with it. The block also returns the physical register that was mapped before, so the pipeline can carry it to commit. At commit that register is handed back through the commit-free port and joins the freelist.

For speculation, one branch checkpoint can be held at a time. Marking a branch saves a copy of the map table and the freelist read position. When the branch resolves correctly the slot is released. When it resolves as mispredicted, the map is reloaded from the copy and the freelist read position is rewound. The registers handed out after the branch then become free again and are issued once more, in the same order. Instructions younger than a held branch are expected not to commit before that branch resolves.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and the freelist holds physical registers NUM_ARCH up to NUM_PHYS-1, handed out in ascending order.
- R2: Source physical indices are combinational reads of the map. They reflect the map as it stands before any write accepted in the same cycle.
- R3: An accepted rename with its write flag set is given the physical register at the freelist head. From the next cycle, that register is the mapping of its destination.
- R4: For a writing rename, the previous-mapping output carries the physical register that the destination mapped to before the rename.
- R5: When the freelist is empty, a rename with its write flag set is not accepted (ready low). A rename without a write is still accepted.
- R6: A commit-free pulse appends its physical register at the freelist tail. Freed registers are handed out in first-in, first-out order after the ones already queued.
- R7: A branch mark is accepted only when no checkpoint is held (mark-ready high). It snapshots the map including a rename accepted in the same cycle. While the checkpoint is held, mark-ready stays low.
- R8: A mispredicted resolve restores the map to the snapshot and rewinds the freelist. The registers handed out after the mark are then reissued in their original order. No rename is accepted in that cycle.
- R9: A correct resolve releases the checkpoint slot and leaves the map and freelist as they are.
- R10: A resolve while no checkpoint is held has no effect on the map, the freelist or mark-ready.
- R11: A commit-free in the same cycle as a mispredicted resolve is kept. Its register is appended at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request present |
| ren_wr_i | input | 1 | Request writes a destination register |
| ren_dst_i | input | AW | Destination architectural register |
| ren_src_a_i | input | AW | First source architectural register |
| ren_src_b_i | input | AW | Second source architectural register |
| ren_ready_o | output | 1 | Rename request can be accepted this cycle |
| ren_src_a_p_o | output | PW | Physical register for first source |
| ren_src_b_p_o | output | PW | Physical register for second source |
| ren_dst_p_o | output | PW | Newly allocated physical register |
| ren_prev_p_o | output | PW | Physical register previously mapped to the destination |
| br_mark_i | input | 1 | Take a checkpoint for a branch |
| br_ready_o | output | 1 | Checkpoint slot free |
| br_done_i | input | 1 | Held branch resolves this cycle |
| br_wrong_i | input | 1 | Resolve is a mispredict |
| cmt_free_i | input | 1 | Return a physical register at commit |
| cmt_preg_i | input | PW | Physical register being returned |

## Verification
The bench aims at the allocation order. A freelist that behaved as a stack, or that skipped the head, would hand out the wrong register right after reset, after a commit-free and after a recovery. It checks a source that names the destination of the same cycle, which a design forwarding the new mapping would return wrongly. Recovery is exercised with a rename in the mark cycle, and also with a commit-free in the mispredict cycle. A snapshot taken before the write, or a recovery that dropped the push, would map or hand out stale registers. The bench drains the freelist completely, so a full/empty pointer slip shows up as a stall that is missing or wrong. It also issues resolves with no checkpoint held, to catch a design that acts on them.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned DEF_ARCH = 32;
  localparam int unsigned DEF_PHYS = 64;

  // Occupancy of a circular queue whose pointers carry one wrap bit.
  function automatic int unsigned ring_used(input int unsigned wr, input int unsigned rd,
                                            input int unsigned span);
    return (wr + 2 * span - rd) % (2 * span);
  endfunction

  // Physical register preloaded into freelist slot j at reset.
  function automatic int unsigned seed_preg(input int unsigned j, input int unsigned base);
    return base + j;
  endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int unsigned DEPTH = 32,   // power of two
  parameter int unsigned PW    = 6,
  parameter int unsigned BASE  = 32,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned PTRW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop_i,
  input  logic            push_i,
  input  logic [PW-1:0]   push_preg_i,
  input  logic            save_i,
  input  logic            restore_i,
  output logic [PW-1:0]   head_preg_o,
  output logic            empty_o,
  output logic [PTRW-1:0] count_o
);
  logic [PW-1:0]   slot_q [DEPTH];
  logic [PTRW-1:0] rd_q, wr_q, saved_rd_q;
  logic [PTRW-1:0] rd_nxt;

  assign count_o     = PTRW'(rn_pkg::ring_used(32'(wr_q), 32'(rd_q), DEPTH));
  assign empty_o     = (count_o == '0);
  assign head_preg_o = slot_q[rd_q[IW-1:0]];

  always_comb begin
    rd_nxt = rd_q;
    if (restore_i)   rd_nxt = saved_rd_q;
    else if (pop_i)  rd_nxt = rd_q + PTRW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= '0;
      wr_q       <= PTRW'(DEPTH);
      saved_rd_q <= '0;
    end else begin
      rd_q <= rd_nxt;
      if (push_i) wr_q <= wr_q + PTRW'(1);
      if (save_i) saved_rd_q <= rd_nxt;
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[j] <= PW'(rn_pkg::seed_preg(j, BASE));
      else if (push_i && wr_q[IW-1:0] == IW'(j))
        slot_q[j] <= push_preg_i;
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NA = 32,
  parameter int unsigned PW = 6,
  localparam int unsigned AW = $clog2(NA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_a_i,
  input  logic [AW-1:0]    rd_b_i,
  input  logic [AW-1:0]    rd_d_i,
  output logic [PW-1:0]    rd_a_o,
  output logic [PW-1:0]    rd_b_o,
  output logic [PW-1:0]    rd_d_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_arch_i,
  input  logic [PW-1:0]    wr_preg_i,
  input  logic             save_i,
  input  logic             restore_i,
  output logic [NA*PW-1:0] map_flat_o,
  output logic [NA*PW-1:0] snap_flat_o
);
  logic [PW-1:0] map_q  [NA];
  logic [PW-1:0] snap_q [NA];

  assign rd_a_o = map_q[rd_a_i];
  assign rd_b_o = map_q[rd_b_i];
  assign rd_d_o = map_q[rd_d_i];

  for (genvar i = 0; i < NA; i++) begin : g_ent
    logic          hit;
    logic [PW-1:0] upd;
    assign hit = wr_en_i && (wr_arch_i == AW'(i));
    assign upd = hit ? wr_preg_i : map_q[i];
    assign map_flat_o[i*PW +: PW]  = map_q[i];
    assign snap_flat_o[i*PW +: PW] = snap_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[i]  <= PW'(i);
        snap_q[i] <= PW'(i);
      end else begin
        map_q[i] <= restore_i ? snap_q[i] : upd;
        if (save_i) snap_q[i] <= upd;
      end
    end
  end
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int unsigned NUM_ARCH = rn_pkg::DEF_ARCH,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned FL_DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int unsigned FCW = $clog2(FL_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid_i,
  input  logic          ren_wr_i,
  input  logic [AW-1:0] ren_dst_i,
  input  logic [AW-1:0] ren_src_a_i,
  input  logic [AW-1:0] ren_src_b_i,
  output logic          ren_ready_o,
  output logic [PW-1:0] ren_src_a_p_o,
  output logic [PW-1:0] ren_src_b_p_o,
  output logic [PW-1:0] ren_dst_p_o,
  output logic [PW-1:0] ren_prev_p_o,
  input  logic          br_mark_i,
  output logic          br_ready_o,
  input  logic          br_done_i,
  input  logic          br_wrong_i,
  input  logic          cmt_free_i,
  input  logic [PW-1:0] cmt_preg_i
);
  // Named internal events (observed by the bound checker).
  logic                   ckpt_busy_q;
  logic                   recover;
  logic                   resolve;
  logic                   ren_fire;
  logic                   alloc;
  logic                   mark_fire;
  logic                   fl_empty;
  logic [FCW-1:0]         fl_count;
  logic [NUM_ARCH*PW-1:0] map_flat;
  logic [NUM_ARCH*PW-1:0] snap_flat;

  assign resolve     = br_done_i && ckpt_busy_q;
  assign recover     = resolve && br_wrong_i;
  assign ren_ready_o = !recover && (!ren_wr_i || !fl_empty);
  assign ren_fire    = ren_valid_i && ren_ready_o;
  assign alloc       = ren_fire && ren_wr_i;
  assign br_ready_o  = !ckpt_busy_q;
  assign mark_fire   = br_mark_i && br_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ckpt_busy_q <= 1'b0;
    else if (mark_fire) ckpt_busy_q <= 1'b1;
    else if (resolve)   ckpt_busy_q <= 1'b0;
  end

  rn_freelist #(.DEPTH(FL_DEPTH), .PW(PW), .BASE(NUM_ARCH)) i_fl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_i       (alloc),
    .push_i      (cmt_free_i),
    .push_preg_i (cmt_preg_i),
    .save_i      (mark_fire),
    .restore_i   (recover),
    .head_preg_o (ren_dst_p_o),
    .empty_o     (fl_empty),
    .count_o     (fl_count)
  );

  rn_map_table #(.NA(NUM_ARCH), .PW(PW)) i_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_i      (ren_src_a_i),
    .rd_b_i      (ren_src_b_i),
    .rd_d_i      (ren_dst_i),
    .rd_a_o      (ren_src_a_p_o),
    .rd_b_o      (ren_src_b_p_o),
    .rd_d_o      (ren_prev_p_o),
    .wr_en_i     (alloc),
    .wr_arch_i   (ren_dst_i),
    .wr_preg_i   (ren_dst_p_o),
    .save_i      (mark_fire),
    .restore_i   (recover),
    .map_flat_o  (map_flat),
    .snap_flat_o (snap_flat)
  );
endmodule

// File: rtl/rename_map_checks.sv
module rename_map_checks #(
  parameter int unsigned NA  = 32,
  parameter int unsigned PW  = 6,
  parameter int unsigned FCW = 6,
  parameter int unsigned FLD = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc,
  input logic          recover,
  input logic          resolve,
  input logic          mark_fire,
  input logic          ckpt_busy,
  input logic          push,
  input logic [FCW-1:0] fl_count,
  input logic [PW-1:0] new_p,
  input logic [PW-1:0] prev_p,
  input logic [NA*PW-1:0] map_flat,
  input logic [NA*PW-1:0] snap_flat
);
  logic new_in_map;
  always_comb begin
    new_in_map = 1'b0;
    for (int i = 0; i < NA; i++)
      if (map_flat[i*PW +: PW] == new_p) new_in_map = 1'b1;
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fl_count) <= FLD);

  a_r3_fresh_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !new_in_map);

  a_r4_prev_differs: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> new_p != prev_p);

  a_r5_no_alloc_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> fl_count != '0);

  a_r3_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !recover) |=> fl_count == FCW'($past(fl_count) - FCW'(1) + FCW'($past(push))));

  a_r8_map_restored: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> map_flat == $past(snap_flat));

  a_r8_no_rename_on_recover: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> !alloc);

  a_r7_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_busy && !resolve) |=> ckpt_busy);

  a_r7_mark_sets: assert property (@(posedge clk) disable iff (!rst_n)
    mark_fire |=> ckpt_busy);
endmodule

bind rename_map_unit rename_map_checks #(
  .NA(NUM_ARCH), .PW(PW), .FCW(FCW), .FLD(FL_DEPTH)
) i_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .alloc     (alloc),
  .recover   (recover),
  .resolve   (resolve),
  .mark_fire (mark_fire),
  .ckpt_busy (ckpt_busy_q),
  .push      (cmt_free_i),
  .fl_count  (fl_count),
  .new_p     (ren_dst_p_o),
  .prev_p    (ren_prev_p_o),
  .map_flat  (map_flat),
  .snap_flat (snap_flat)
);

// File: tb/test_rename_map_unit.sv
`timescale 1ns/1ps
module test_rename_map_unit;
  localparam int NA = 32;
  localparam int NP = 64;
  localparam int FD = NP - NA;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ren_valid_i = 0, ren_wr_i = 0;
  logic [4:0] ren_dst_i = 0, ren_src_a_i = 0, ren_src_b_i = 0;
  logic       ren_ready_o;
  logic [5:0] ren_src_a_p_o, ren_src_b_p_o, ren_dst_p_o, ren_prev_p_o;
  logic       br_mark_i = 0, br_ready_o, br_done_i = 0, br_wrong_i = 0;
  logic       cmt_free_i = 0;
  logic [5:0] cmt_preg_i = 0;

  always #2 clk = ~clk;

  rename_map_unit i_rename_map_unit (.*);

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // Bench reference state
  int m_map[NA];
  int m_fl[FD];
  int m_hd, m_tl;
  int k_map[NA];
  int k_hd;
  bit k_busy;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, check before posedge, update model after.
  task automatic cycle(input bit rv, input bit we, input int dst, input int sa, input int sb,
                       input bit mark, input bit done, input bit wrong,
                       input bit cf, input int cp, input string req);
    bit exp_rdy, recov, fire;
    @(negedge clk);
    ren_valid_i = rv; ren_wr_i = we; ren_dst_i = 5'(dst);
    ren_src_a_i = 5'(sa); ren_src_b_i = 5'(sb);
    br_mark_i = mark; br_done_i = done; br_wrong_i = wrong;
    cmt_free_i = cf; cmt_preg_i = 6'(cp);
    #1;
    recov   = done && wrong && k_busy;
    exp_rdy = !recov && (!we || (m_tl - m_hd) > 0);
    chk({req, " ren_ready"}, int'(ren_ready_o), int'(exp_rdy));
    chk({req, " br_ready"}, int'(br_ready_o), int'(!k_busy));
    if (rv) begin
      chk({req, " src_a"}, int'(ren_src_a_p_o), m_map[sa]);
      chk({req, " src_b"}, int'(ren_src_b_p_o), m_map[sb]);
    end
    if (rv && we && exp_rdy) begin
      chk({req, " new dst"}, int'(ren_dst_p_o), m_fl[m_hd % FD]);
      chk({req, " prev dst"}, int'(ren_prev_p_o), m_map[dst]);
    end
    fire = rv && exp_rdy;
    @(posedge clk);
    if (recov) begin
      foreach (m_map[i]) m_map[i] = k_map[i];
      m_hd = k_hd;
    end
    if (done && k_busy) k_busy = 0;
    else if (mark && !k_busy) begin
      if (fire && we) begin m_map[dst] = m_fl[m_hd % FD]; m_hd++; end
      foreach (m_map[i]) k_map[i] = m_map[i];
      k_hd = m_hd; k_busy = 1;
      fire = 0;
    end
    if (fire && we) begin m_map[dst] = m_fl[m_hd % FD]; m_hd++; end
    if (cf) begin m_fl[m_tl % FD] = cp; m_tl++; end
    #1;
    ren_valid_i = 0; ren_wr_i = 0; br_mark_i = 0; br_done_i = 0;
    br_wrong_i = 0; cmt_free_i = 0;
  endtask

  task automatic ren(input int dst, input int sa, input int sb, input string req);
    cycle(1, 1, dst, sa, sb, 0, 0, 0, 0, 0, req);
  endtask

  task automatic t_reset;
    cycle(1, 0, 0, 0, 31, 0, 0, 0, 0, 0, "R1 identity");
    cycle(1, 0, 0, 17, 9, 0, 0, 0, 0, 0, "R1 identity");
    chk("R1 first free", int'(ren_dst_p_o), 32);
  endtask

  task automatic t_basic;
    ren(3, 1, 2, "R3 first alloc");
    cycle(1, 0, 0, 3, 4, 0, 0, 0, 0, 0, "R3 map updated");
    ren(3, 3, 3, "R4 prev is earlier new");
    ren(5, 5, 3, "R2 same-cycle src sees old map");
    cycle(1, 0, 0, 5, 3, 0, 0, 0, 0, 0, "R2 next cycle sees new");
  endtask

  task automatic t_commit;
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R6 commit free");
    ren(10, 10, 11, "R6 fifo order head");
  endtask

  task automatic t_mispredict;
    cycle(1, 1, 7, 7, 8, 1, 0, 0, 0, 0, "R7 mark with rename");
    ren(8, 7, 8, "R7 spec rename");
    ren(9, 8, 9, "R7 spec rename");
    cycle(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 second mark stalls");
    cycle(1, 1, 12, 8, 9, 0, 1, 1, 1, 5, "R8 R11 mispredict blocks rename");
    cycle(1, 0, 0, 7, 8, 0, 0, 0, 0, 0, "R8 map restored");
    ren(8, 9, 7, "R8 reissue first spec reg");
    ren(9, 9, 8, "R8 reissue second spec reg");
  endtask

  task automatic t_resolve_ok;
    cycle(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 mark");
    ren(20, 20, 21, "R9 spec rename");
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 correct resolve");
    cycle(1, 0, 0, 20, 21, 0, 0, 0, 0, 0, "R9 map kept");
  endtask

  task automatic t_stray;
    cycle(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R10 resolve with no checkpoint");
    cycle(1, 0, 0, 20, 8, 0, 0, 0, 0, 0, "R10 map untouched");
    ren(21, 21, 20, "R10 freelist untouched");
  endtask

  task automatic t_exhaust;
    for (int n = 0; n < 40; n++) ren(n % NA, (n + 1) % NA, n % NA, "R5 drain");
    chk("R5 freelist empty", int'(m_tl - m_hd), 0);
    cycle(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, "R5 non-writer proceeds");
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 40, "R6 free into empty");
    ren(6, 6, 7, "R6 freed reg handed out");
  endtask

  initial begin
    foreach (m_map[i]) begin m_map[i] = i; k_map[i] = i; end
    for (int j = 0; j < FD; j++) m_fl[j] = NA + j;
    m_hd = 0; m_tl = FD; k_hd = 0; k_busy = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_commit();
    t_mispredict();
    t_resolve_ok();
    t_stray();
    t_exhaust();
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule